// File: doc/BRIEF.md
# Linear Systolic 4x4 Matrix Multiplier

This block forms the product C = A·B of two 4×4 matrices of signed 16-bit elements on a one-dimensional chain of four processing elements. Each pass issues a stream of result slots, one slot per cycle per lane. Every slot names one result element (row, column). The slot travels down the chain, and stage k adds the term A[row][k]·B[k][col] to the partial sum that arrives from the stage before it. The first stage holds a multiplier only. After the fourth stage, the finished sum leaves the block with its row and column index.

The slots are issued in diagonal order. In the base configuration a single lane walks the four wrapped diagonals in turn, so the 16 results take N + N² = 20 cycles. In the refined configuration a second lane runs next to the first. Each lane covers two diagonals, because the multiplier row order is rotated by two positions after the first four slots. All 16 results then appear within N + 2N = 12 cycles. A one-cycle done pulse closes each pass. The operand matrices are applied on wide input buses and captured when a pass starts.

Top module: `sysmm_top`

## Requirements
- R1: A start_i pulse while the block is idle captures a_i, b_i and mode_i for the whole pass. A start_i while a pass is in progress is ignored, and so are any changes to a_i and b_i during the pass. Element (r,c) sits at bits [(4r+c)·16 +: 16] of each matrix bus.
- R2: Every result equals the sum over k of A[r][k]·B[k][c]. It is computed at full 34-bit signed precision, so it is exact even when all operands are −32768.
- R3: With mode_i = 0 (base), lane 0 delivers 16 results on consecutive cycles. The first result arrives on the fourth clock edge after the edge that accepted start. Result s has row s mod 4 and column (s mod 4 + s div 4) mod 4.
- R4: With mode_i = 1 (refined), lanes 0 and 1 are valid together for 8 consecutive cycles, starting at the same edge as in R3. For slot s, both lanes carry row s mod 4. Lane 0 carries column (row + 2·(s div 4)) mod 4, and lane 1 carries that column plus one, mod 4.
- R5: done_o is high for exactly one cycle, one cycle after the last result. That is 20 edges after the accepting edge in base mode and 12 edges after it in refined mode.
- R6: Lane 1 is never valid in base mode, and no result is valid outside the result window of a pass.
- R7: While reset is asserted and after it is released, no result is valid and done_o is low until a pass is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a pass (accepted only when idle) |
| mode_i | input | 1 | 0 = single lane base, 1 = dual lane refined |
| a_i | input | 256 | Multiplicand matrix A, row-major, 16-bit signed elements |
| b_i | input | 256 | Multiplier matrix B, row-major, 16-bit signed elements |
| res_vld_o | output | 2 | Result valid per lane |
| res_row_o | output | 4 | Row index per lane, lane l at [2l +: 2] |
| res_col_o | output | 4 | Column index per lane, lane l at [2l +: 2] |
| res_data_o | output | 68 | 34-bit signed result per lane, lane l at [34l +: 34] |
| done_o | output | 1 | One-cycle pulse after the last result of a pass |

## Verification
A fault in the slot sequencer shows at the ports as a wrong row or column index, or as a gap in the valid window, from the first result onward. That is four cycles after start. A fault in one chain stage corrupts a single term of every sum that passes through it. It therefore appears in the first result data compared after the pipeline fills. Operands set to the most negative value are used to expose truncated accumulators. A start issued in the middle of a pass, with changed buses, exposes a capture register that is not held for the whole pass.

// File: rtl/sysmm_pkg.sv
package sysmm_pkg;
  localparam int N  = 4;
  localparam int IW = $clog2(N);

  typedef struct packed {
    logic          vld;
    logic          lst;
    logic [IW-1:0] row;
    logic [IW-1:0] col;
  } tag_t;
endpackage

// File: rtl/sysmm_seq.sv
module sysmm_seq
  import sysmm_pkg::*;
#(
  parameter int NLANE = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  go_i,
  input  logic                  mode_i,
  output tag_t [NLANE-1:0]      tag_o
);
  localparam int CW = 2 * IW;
  localparam logic [CW-1:0] LAST_BASE = CW'(N * N - 1);
  localparam logic [CW-1:0] LAST_REF  = CW'(2 * N - 1);

  logic          act_q, mode_q;
  logic [CW-1:0] idx_q;
  logic [CW-1:0] last;
  logic [IW-1:0] row, grp;

  assign last = mode_q ? LAST_REF : LAST_BASE;
  assign row  = idx_q[IW-1:0];
  assign grp  = idx_q[CW-1:IW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      mode_q <= 1'b0;
      idx_q  <= '0;
    end else if (go_i) begin
      act_q  <= 1'b1;
      mode_q <= mode_i;
      idx_q  <= '0;
    end else if (act_q) begin
      if (idx_q == last) begin
        act_q <= 1'b0;
        idx_q <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // lane l in refined mode starts on diagonal l and jumps two diagonals
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    always_comb begin
      tag_o[l].vld = act_q && (l == 0 || mode_q);
      tag_o[l].lst = act_q && (idx_q == last);
      tag_o[l].row = row;
      if (mode_q) tag_o[l].col = row + {grp[0], 1'b0} + IW'(l);
      else        tag_o[l].col = row + grp;
    end
  end
endmodule

// File: rtl/sysmm_pe.sv
module sysmm_pe
  import sysmm_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 2 * DW + 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  tag_t                   tag_i,
  input  logic signed [AW-1:0]   psum_i,
  input  logic [N-1:0][DW-1:0]   acol_i,
  input  logic [N-1:0][DW-1:0]   brow_i,
  output tag_t                   tag_o,
  output logic signed [AW-1:0]   psum_o
);
  logic signed [AW-1:0] a_x, b_x, prod;

  always_comb begin
    a_x  = AW'($signed(acol_i[tag_i.row]));
    b_x  = AW'($signed(brow_i[tag_i.col]));
    prod = a_x * b_x;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_o  <= '0;
      psum_o <= '0;
    end else begin
      tag_o  <= tag_i;
      psum_o <= psum_i + prod;
    end
  end
endmodule

// File: rtl/sysmm_top.sv
module sysmm_top
  import sysmm_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NLANE = 2,
  parameter int AW    = 2 * DW + 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   mode_i,
  input  logic [N*N*DW-1:0]      a_i,
  input  logic [N*N*DW-1:0]      b_i,
  output logic [NLANE-1:0]       res_vld_o,
  output logic [NLANE*IW-1:0]    res_row_o,
  output logic [NLANE*IW-1:0]    res_col_o,
  output logic [NLANE*AW-1:0]    res_data_o,
  output logic                   done_o
);
  logic [N-1:0][N-1:0][DW-1:0] a_q, b_q;
  logic [N-1:0][N-1:0][DW-1:0] a_col;
  logic                        busy_q, go, fin;
  tag_t [NLANE-1:0]            seq_tag;
  tag_t                        tg [NLANE][N+1];
  logic signed [AW-1:0]        ps [NLANE][N+1];

  assign go = start_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (go) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  // stage k sees column k of A
  for (genvar k = 0; k < N; k++) begin : g_acol
    for (genvar r = 0; r < N; r++) begin : g_r
      assign a_col[k][r] = a_q[r][k];
    end
  end

  sysmm_seq #(.NLANE(NLANE)) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .mode_i (mode_i),
    .tag_o  (seq_tag)
  );

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign tg[l][0] = seq_tag[l];
    assign ps[l][0] = '0;
    for (genvar k = 0; k < N; k++) begin : g_pe
      sysmm_pe #(.DW(DW), .AW(AW)) i_pe (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tag_i  (tg[l][k]),
        .psum_i (ps[l][k]),
        .acol_i (a_col[k]),
        .brow_i (b_q[k]),
        .tag_o  (tg[l][k+1]),
        .psum_o (ps[l][k+1])
      );
    end
    assign res_vld_o[l]              = tg[l][N].vld;
    assign res_row_o[l*IW +: IW]     = tg[l][N].row;
    assign res_col_o[l*IW +: IW]     = tg[l][N].col;
    assign res_data_o[l*AW +: AW]    = ps[l][N];
  end

  always_comb begin
    fin = 1'b0;
    for (int l = 0; l < NLANE; l++) fin = fin | (tg[l][N].vld & tg[l][N].lst);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= fin;
      if (go)       busy_q <= 1'b1;
      else if (fin) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sysmm_chk.sv
module sysmm_chk
  import sysmm_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NLANE = 2,
  parameter int AW    = 2 * DW + 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                mode_i,
  input logic [N*N*DW-1:0]   a_i,
  input logic [N*N*DW-1:0]   b_i,
  input logic [NLANE-1:0]    res_vld_o,
  input logic [NLANE*IW-1:0] res_row_o,
  input logic [NLANE*IW-1:0] res_col_o,
  input logic [NLANE*AW-1:0] res_data_o,
  input logic                done_o
);
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r5_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(res_vld_o[0]) && !res_vld_o[0]));

  a_r3_row_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o[0] && $past(res_vld_o[0])) |->
      (res_row_o[IW-1:0] == $past(res_row_o[IW-1:0]) + IW'(1)));

  a_r4_lane_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o[1] |-> (res_vld_o[0] &&
                      res_row_o[2*IW-1:IW] == res_row_o[IW-1:0] &&
                      res_col_o[2*IW-1:IW] == res_col_o[IW-1:0] + IW'(1)));

  a_r6_window_ends_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(res_vld_o[0]) |-> done_o);
endmodule

bind sysmm_top sysmm_chk #(.DW(DW), .NLANE(NLANE), .AW(AW)) i_chk (.*);

// File: tb/test_sysmm_top.sv
module test_sysmm_top;
  localparam int DW = 16;
  localparam int AW = 34;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic             mode_i = 1'b0;
  logic [255:0]     a_i = '0;
  logic [255:0]     b_i = '0;
  logic [1:0]       res_vld_o;
  logic [3:0]       res_row_o, res_col_o;
  logic [2*AW-1:0]  res_data_o;
  logic             done_o;

  int checks = 0;
  int errors = 0;
  int am [4][4];
  int bm [4][4];

  always #5 clk_i = ~clk_i;

  sysmm_top i_sysmm_top (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic longint ref_c(int r, int c);
    longint s = 0;
    for (int k = 0; k < 4; k++) s += longint'(am[r][k]) * longint'(bm[k][c]);
    return s;
  endfunction

  // kind 0 random, 1 all min, 2 min/max mix
  task automatic load(input int kind);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        case (kind)
          1: begin am[r][c] = -32768; bm[r][c] = -32768; end
          2: begin am[r][c] = ((r + c) % 2) ? 32767 : -32768; bm[r][c] = -32768; end
          default: begin
            am[r][c] = int'($signed(16'($urandom())));
            bm[r][c] = int'($signed(16'($urandom())));
          end
        endcase
        a_i[(r*4+c)*16 +: 16] = 16'(am[r][c]);
        b_i[(r*4+c)*16 +: 16] = 16'(bm[r][c]);
      end
  endtask

  task automatic run_pass(input bit md, input bit disturb);
    int total = md ? 12 : 20;
    int cnt   = md ? 8 : 16;
    @(negedge clk_i);
    start_i = 1'b1; mode_i = md;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 1; k <= total + 3; k++) begin
      @(negedge clk_i);
      begin
        bit e0 = (k >= 4) && (k < 4 + cnt);
        int s = k - 4;
        int row = (s % 4 + 4) % 4;
        int grp = s / 4;
        int c0 = md ? (row + 2 * grp) % 4 : (row + grp) % 4;
        int c1 = (row + 2 * grp + 1) % 4;
        longint d0 = $signed(res_data_o[AW-1:0]);
        longint d1 = $signed(res_data_o[2*AW-1:AW]);
        chk(res_vld_o[0] == e0, md ? "R4 lane0 valid" : "R3 lane0 valid", res_vld_o[0], e0);
        chk(res_vld_o[1] == (e0 && md), md ? "R4 lane1 valid" : "R6 lane1 idle", res_vld_o[1], e0 && md);
        chk(done_o == (k == total), "R5 done timing", done_o, k == total);
        if (e0) begin
          chk(res_row_o[1:0] == row, md ? "R4 row" : "R3 row", res_row_o[1:0], row);
          chk(res_col_o[1:0] == c0, md ? "R4 col" : "R3 col", res_col_o[1:0], c0);
          chk(d0 == ref_c(row, c0), disturb ? "R1 held data" : "R2 data", d0, ref_c(row, c0));
          if (md) begin
            chk(res_row_o[3:2] == row, "R4 lane1 row", res_row_o[3:2], row);
            chk(res_col_o[3:2] == c1, "R4 lane1 col", res_col_o[3:2], c1);
            chk(d1 == ref_c(row, c1), "R2 lane1 data", d1, ref_c(row, c1));
          end
        end
      end
      if (disturb && k == 6) begin
        start_i = 1'b1; mode_i = ~md;
        a_i = {8{$urandom()}}; b_i = {8{$urandom()}};
      end
      if (k == 7) start_i = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL R5 watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk_i);
    chk(res_vld_o == 2'b00, "R7 reset valid", res_vld_o, 0);
    chk(done_o == 1'b0, "R7 reset done", done_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(res_vld_o == 2'b00 && !done_o, "R7 idle after reset", res_vld_o, 0);
    for (int i = 0; i < 3; i++) begin load(0); run_pass(1'b0, 1'b0); end
    for (int i = 0; i < 3; i++) begin load(0); run_pass(1'b1, 1'b0); end
    load(1); run_pass(1'b0, 1'b0);
    load(1); run_pass(1'b1, 1'b0);
    load(2); run_pass(1'b0, 1'b0);
    load(2); run_pass(1'b1, 1'b0);
    load(0); run_pass(1'b0, 1'b1);
    load(0); run_pass(1'b1, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule